// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Clock Outputs

This block controls sixteen general-purpose pins through a small word-addressed register port. Each pin has its own direction bit and output data bit. The level on every pin passes through a two-flop synchroniser before software reads it back. Pins 0 to 12 can also raise an interrupt. Each of those pins has its own trigger setting (active-high level, active-low level, rising edge, falling edge, either edge, or off) and its own enable bit. All enabled status bits are combined into a single interrupt line.

Pins 14 and 15 can each be handed to a built-in clock generator. The high time and the low time of the waveform are each programmed as a number of system-clock cycles. With a 66.66 MHz system clock, the fastest setting gives 33.33 MHz. Pin 15 comes out of reset already driving its clock. Pin 14 comes out of reset as an ordinary input. When a generator is switched off, its pin is plain GPIO again.

Register map (word addresses, read is combinational): 0 direction, 1 output data, 2 synchronised input (read-only), 3 interrupt enable, 4 interrupt status, 5 trigger codes for pins 0-7, 6 trigger codes for pins 8-12, 7 clock-mode control, 8 pin-14 timing, 9 pin-15 timing.

Top module: `gpio_bank`

## Requirements
- R1: After reset, registers 0, 1 and 3 read 0, register 7 reads 2, register 5 reads 0xFFFFFF, register 6 reads 0x7FFF, and padOutEn is 0x8000 with pin 15 driven by its clock.
- R2: When not in clock mode, padOutEn[i] equals bit i of register 0 (1 = output) and padOut[i] equals bit i of register 1.
- R3: Register 2 shows padIn through two flops: a change made just before a clock edge is not visible after one edge and is visible after two edges.
- R4: Pins 13-15 can never raise an interrupt. Bits 15:13 of registers 3 and 4 always read 0, and toggling those pins leaves irq low.
- R5: Pin i's 3-bit trigger code sits at bits [3*(i%8)+2 : 3*(i%8)] of register 5 (i < 8) or register 6 (i >= 8). The codes are 0 high level, 1 low level, 2 rising edge, 3 falling edge, 4 either edge, and 5-7 off. Off keeps the status bit at 0.
- R6: In the edge modes a status bit is sticky. It clears only when 1 is written to its bit in register 4, and writing 0 has no effect.
- R7: In the level modes a status bit follows the synchronised input one cycle later and cannot be cleared by a write.
- R8: irq is high exactly when some status bit and its enable bit in register 3 are both 1.
- R9: Bit 0 of register 7 puts pin 14 in clock mode and bit 1 puts pin 15 in clock mode. In clock mode the pin is driven (padOutEn = 1). The waveform is high for H+1 cycles and low for L+1 cycles, where H is bits [7:0] and L is bits [15:8] of the pin's timing register.
- R10: With its clock mode off, pin 14 or 15 follows registers 0 and 1 like any other pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register word address for read and write |
| regWrEn | input | 1 | Write strobe for regAddr |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| padIn | input | 16 | Levels observed on the pins |
| padOut | output | 16 | Values driven to the pins |
| padOutEn | output | 16 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest part to observe from the ports is the shape of a clock waveform. Its phase at any moment depends on how many cycles have passed since the generator was last enabled. The stimulus therefore counts high samples over a window that is a whole number of periods, which gives a count that does not depend on phase. A second hard case is the sticky edge status. It takes several cycles to appear because of the synchroniser, so the stimulus toggles pins in one mode, changes the trigger code, and then toggles again. This shows that edges accumulate, that a single write-one clears only its own bit, and that a write of zero changes nothing.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int unsigned PIN_CNT        = 16;
  localparam int unsigned IRQ_CNT        = 13;
  localparam int unsigned MODE_W         = 3;
  localparam int unsigned MODES_PER_WORD = 8;
  localparam int unsigned ADDR_W         = 4;
  localparam int unsigned DATA_W         = 32;
  localparam int unsigned WDATA_W        = MODES_PER_WORD * MODE_W;
  localparam int unsigned CLK_CNT        = 2;
  localparam int unsigned CLK_BASE       = PIN_CNT - CLK_CNT;
  localparam logic [CLK_CNT-1:0] CLK_EN_RST = 2'b10;

  localparam logic [ADDR_W-1:0] A_DIR  = 4'd0;
  localparam logic [ADDR_W-1:0] A_OUT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_IN   = 4'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd4;
  localparam logic [ADDR_W-1:0] A_TRG0 = 4'd5;
  localparam logic [ADDR_W-1:0] A_TRG1 = 4'd6;
  localparam logic [ADDR_W-1:0] A_CCTL = 4'd7;
  localparam logic [ADDR_W-1:0] A_TIM0 = 4'd8;
  localparam logic [ADDR_W-1:0] A_TIM1 = 4'd9;

  localparam logic [MODE_W-1:0] M_HIGH = 3'd0;
  localparam logic [MODE_W-1:0] M_LOW  = 3'd1;
  localparam logic [MODE_W-1:0] M_RISE = 3'd2;
  localparam logic [MODE_W-1:0] M_FALL = 3'd3;
  localparam logic [MODE_W-1:0] M_BOTH = 3'd4;
  localparam logic [MODE_W-1:0] M_OFF  = 3'd7;

  typedef struct packed {
    logic               wrDir;
    logic               wrOut;
    logic               wrIen;
    logic               wrStat;
    logic [1:0]         wrTrig;
    logic               wrCctl;
    logic [CLK_CNT-1:0] wrTim;
    logic [ADDR_W-1:0]  rdSel;
    logic [WDATA_W-1:0] wdata;
  } regStb_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
`timescale 1ns/1ps
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output regStb_t           stb
);
  logic unusedHiBits;
  assign unusedHiBits = ^regWrData[DATA_W-1:WDATA_W];

  always_comb begin
    stb       = '0;
    stb.rdSel = regAddr;
    stb.wdata = regWrData[WDATA_W-1:0];
    if (regWrEn) begin
      case (regAddr)
        A_DIR:   stb.wrDir     = 1'b1;
        A_OUT:   stb.wrOut     = 1'b1;
        A_IEN:   stb.wrIen     = 1'b1;
        A_STAT:  stb.wrStat    = 1'b1;
        A_TRG0:  stb.wrTrig[0] = 1'b1;
        A_TRG1:  stb.wrTrig[1] = 1'b1;
        A_CCTL:  stb.wrCctl    = 1'b1;
        A_TIM0:  stb.wrTim[0]  = 1'b1;
        A_TIM1:  stb.wrTim[1]  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_clkgen.sv
`timescale 1ns/1ps
module gpio_bank_clkgen #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [CNT_W-1:0] hiCnt,
  input  logic [CNT_W-1:0] loCnt,
  output logic             wave
);
  logic             phaseHigh;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseHigh <= 1'b1;
      cnt       <= '0;
    end else if (!en) begin
      phaseHigh <= 1'b1;
      cnt       <= '0;
    end else if (phaseHigh) begin
      if (cnt >= hiCnt) begin
        phaseHigh <= 1'b0;
        cnt       <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      if (cnt >= loCnt) begin
        phaseHigh <= 1'b1;
        cnt       <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign wave = en & phaseHigh;
endmodule

// File: rtl/gpio_bank_dp.sv
`timescale 1ns/1ps
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  regStb_t                   stb,
  input  logic [PIN_CNT-1:0]        padIn,
  output logic [DATA_W-1:0]         regRdData,
  output logic [PIN_CNT-1:0]        padOut,
  output logic [PIN_CNT-1:0]        padOutEn,
  output logic                      irq,
  output logic [IRQ_CNT-1:0]        statusQ,
  output logic [PIN_CNT-1:0]        outQ,
  output logic [CLK_CNT-1:0]        clkEnQ,
  output logic [IRQ_CNT*MODE_W-1:0] trigFlat,
  output logic [2*CNT_W-1:0]        tim1Q
);
  localparam int unsigned TIM_W    = 2 * CNT_W;
  localparam int unsigned TRIG_PAD = 2 * WDATA_W - IRQ_CNT * MODE_W;

  logic [PIN_CNT-1:0]   dirQ;
  logic [IRQ_CNT-1:0]   ienQ;
  logic [TIM_W-1:0]     timQ [CLK_CNT];
  logic [PIN_CNT-1:0]   syncA, syncB;
  logic [IRQ_CNT-1:0]   prevB;
  logic [CLK_CNT-1:0]   wave;
  logic [2*WDATA_W-1:0] trigAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ   <= '0;
      outQ   <= '0;
      ienQ   <= '0;
      clkEnQ <= CLK_EN_RST;
      for (int k = 0; k < CLK_CNT; k++) timQ[k] <= '0;
    end else begin
      if (stb.wrDir)  dirQ   <= stb.wdata[PIN_CNT-1:0];
      if (stb.wrOut)  outQ   <= stb.wdata[PIN_CNT-1:0];
      if (stb.wrIen)  ienQ   <= stb.wdata[IRQ_CNT-1:0];
      if (stb.wrCctl) clkEnQ <= stb.wdata[CLK_CNT-1:0];
      for (int k = 0; k < CLK_CNT; k++)
        if (stb.wrTim[k]) timQ[k] <= stb.wdata[TIM_W-1:0];
    end
  end

  // two-flop synchroniser plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      prevB <= syncB[IRQ_CNT-1:0];
    end
  end

  for (genvar i = 0; i < IRQ_CNT; i++) begin : g_irq
    localparam int unsigned WSEL = i / MODES_PER_WORD;
    localparam int unsigned OFS  = (i % MODES_PER_WORD) * MODE_W;
    logic [MODE_W-1:0] modeR;
    logic              statR;
    logic              rise, fall, lvlMode, lvlHit, edgeMode, edgeHit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 modeR <= M_OFF;
      else if (stb.wrTrig[WSEL]) modeR <= stb.wdata[OFS +: MODE_W];
    end

    assign rise = syncB[i] & ~prevB[i];
    assign fall = ~syncB[i] & prevB[i];

    always_comb begin
      lvlMode  = 1'b0;
      lvlHit   = 1'b0;
      edgeMode = 1'b0;
      edgeHit  = 1'b0;
      case (modeR)
        M_HIGH: begin lvlMode  = 1'b1; lvlHit  = syncB[i];    end
        M_LOW:  begin lvlMode  = 1'b1; lvlHit  = ~syncB[i];   end
        M_RISE: begin edgeMode = 1'b1; edgeHit = rise;        end
        M_FALL: begin edgeMode = 1'b1; edgeHit = fall;        end
        M_BOTH: begin edgeMode = 1'b1; edgeHit = rise | fall; end
        default: ;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          statR <= 1'b0;
      else if (lvlMode)                   statR <= lvlHit;
      else if (!edgeMode)                 statR <= 1'b0;
      else if (edgeHit)                   statR <= 1'b1;
      else if (stb.wrStat && stb.wdata[i]) statR <= 1'b0;
    end

    assign statusQ[i]                  = statR;
    assign trigFlat[i*MODE_W +: MODE_W] = modeR;
  end

  for (genvar k = 0; k < CLK_CNT; k++) begin : g_clk
    gpio_bank_clkgen #(.CNT_W(CNT_W)) u_gen (
      .clk  (clk),
      .rstN (rstN),
      .en   (clkEnQ[k]),
      .hiCnt(timQ[k][CNT_W-1:0]),
      .loCnt(timQ[k][TIM_W-1:CNT_W]),
      .wave (wave[k])
    );
  end

  always_comb begin
    padOut   = outQ;
    padOutEn = dirQ;
    for (int k = 0; k < CLK_CNT; k++) begin
      if (clkEnQ[k]) begin
        padOut[CLK_BASE+k]   = wave[k];
        padOutEn[CLK_BASE+k] = 1'b1;
      end
    end
  end

  assign irq     = |(statusQ & ienQ);
  assign tim1Q   = timQ[1];
  assign trigAll = {{TRIG_PAD{1'b0}}, trigFlat};

  always_comb begin
    regRdData = '0;
    case (stb.rdSel)
      A_DIR:   regRdData[PIN_CNT-1:0] = dirQ;
      A_OUT:   regRdData[PIN_CNT-1:0] = outQ;
      A_IN:    regRdData[PIN_CNT-1:0] = syncB;
      A_IEN:   regRdData[IRQ_CNT-1:0] = ienQ;
      A_STAT:  regRdData[IRQ_CNT-1:0] = statusQ;
      A_TRG0:  regRdData[WDATA_W-1:0] = trigAll[WDATA_W-1:0];
      A_TRG1:  regRdData[WDATA_W-1:0] = trigAll[2*WDATA_W-1:WDATA_W];
      A_CCTL:  regRdData[CLK_CNT-1:0] = clkEnQ;
      A_TIM0:  regRdData[TIM_W-1:0]   = timQ[0];
      A_TIM1:  regRdData[TIM_W-1:0]   = timQ[1];
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [15:0]       padIn,
  output logic [15:0]       padOut,
  output logic [15:0]       padOutEn,
  output logic              irq
);
  regStb_t                   stb;
  logic [IRQ_CNT-1:0]        statusQ;
  logic [PIN_CNT-1:0]        outQ;
  logic [CLK_CNT-1:0]        clkEnQ;
  logic [IRQ_CNT*MODE_W-1:0] trigFlat;
  logic [2*CNT_W-1:0]        tim1Q;
  logic                      statWr;

  gpio_bank_ctrl u_ctrl (
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .stb      (stb)
  );

  gpio_bank_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .padIn    (padIn),
    .regRdData(regRdData),
    .padOut   (padOut),
    .padOutEn (padOutEn),
    .irq      (irq),
    .statusQ  (statusQ),
    .outQ     (outQ),
    .clkEnQ   (clkEnQ),
    .trigFlat (trigFlat),
    .tim1Q    (tim1Q)
  );

  assign statWr = stb.wrStat;
endmodule

// File: rtl/gpio_bank_chk.sv
`timescale 1ns/1ps
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      padIn0,
  input logic [1:0]                padOutHi,
  input logic [PIN_CNT-1:0]        padOutEn,
  input logic [IRQ_CNT-1:0]        statusQ,
  input logic                      outQ14,
  input logic [CLK_CNT-1:0]        clkEnQ,
  input logic [IRQ_CNT*MODE_W-1:0] trigFlat,
  input logic [2*CNT_W-1:0]        tim1Q,
  input logic                      statWr
);
  logic [IRQ_CNT-1:0] edgeMask;
  logic [CNT_W+1:0]   hiRun;
  logic [2*CNT_W-1:0] timPrev;

  for (genvar i = 0; i < IRQ_CNT; i++) begin : g_mask
    assign edgeMask[i] = (trigFlat[i*MODE_W +: MODE_W] == M_RISE) ||
                         (trigFlat[i*MODE_W +: MODE_W] == M_FALL) ||
                         (trigFlat[i*MODE_W +: MODE_W] == M_BOTH);
  end

  // length of the current high run on pin 15 while its generator is on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun   <= '0;
      timPrev <= '0;
    end else begin
      timPrev <= tim1Q;
      if (!clkEnQ[1] || !padOutHi[1] || (tim1Q != timPrev)) hiRun <= '0;
      else                                                  hiRun <= hiRun + 1'b1;
    end
  end

  assert_reset_pads_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (padOutEn == 16'h8000) && padOutHi[1]);

  assert_sticky_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(statWr) && $stable(edgeMask)) |->
      ((statusQ & $past(statusQ & edgeMask)) == $past(statusQ & edgeMask)));

  assert_level_follow_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(trigFlat[MODE_W-1:0]) == M_HIGH) |-> (statusQ[0] == $past(padIn0, 3)));

  assert_high_run_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clkEnQ[1] && padOutHi[1] && (tim1Q == timPrev)) |->
      (hiRun <= {2'b00, tim1Q[CNT_W-1:0]}));

  assert_gpio_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnQ[0] && $past(!clkEnQ[0]) && $stable(outQ14)) |-> $stable(padOutHi[0]));
endmodule

bind gpio_bank gpio_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .padIn0  (padIn[0]),
  .padOutHi(padOut[15:14]),
  .padOutEn(padOutEn),
  .statusQ (statusQ),
  .outQ14  (outQ[14]),
  .clkEnQ  (clkEnQ),
  .trigFlat(trigFlat),
  .tim1Q   (tim1Q),
  .statWr  (statWr)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] padIn = '0;
  logic [15:0] padOut, padOutEn;
  logic        irq;

  always #4 clk = ~clk;

  gpio_bank u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .padIn(padIn),
    .padOut(padOut), .padOutEn(padOutEn), .irq(irq)
  );

  typedef struct {
    int          kind;   // 0 register, 1 padOut, 2 padOutEn, 3 irq
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } item_t;

  item_t       sbq[$];
  item_t       monItem;
  logic [31:0] monAct;
  int          nRun = 0;
  int          nFail = 0;
  bit          done = 1'b0;

  task automatic report(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares one queued expectation just after each falling edge
  always @(negedge clk) begin
    #1;
    if (sbq.size() != 0) begin
      monItem = sbq.pop_front();
      case (monItem.kind)
        0:       monAct = regRdData;
        1:       monAct = {16'h0, padOut};
        2:       monAct = {16'h0, padOutEn};
        default: monAct = {31'h0, irq};
      endcase
      report((monAct & monItem.mask) == (monItem.exp & monItem.mask),
             monItem.tag, monAct & monItem.mask, monItem.exp & monItem.mask);
    end
  end

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic chkReg(input logic [3:0] a, input logic [31:0] e,
                        input logic [31:0] m, input string tag);
    @(negedge clk);
    regAddr = a;
    sbq.push_back('{0, e, m, tag});
  endtask

  task automatic chkPort(input int kind, input logic [31:0] e,
                         input logic [31:0] m, input string tag);
    @(negedge clk);
    sbq.push_back('{kind, e, m, tag});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setIn(input logic [15:0] v);
    @(negedge clk);
    padIn = v;
  endtask

  task automatic countHigh(input int cycles, output int c14, output int c15);
    c14 = 0; c15 = 0;
    for (int j = 0; j < cycles; j++) begin
      @(negedge clk); #2;
      c14 += int'(padOut[14]);
      c15 += int'(padOut[15]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : driver
    int h14, h15;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chkReg(4'd0, 32'h0, 32'hFFFFFFFF, "R1 direction reset");
    chkReg(4'd1, 32'h0, 32'hFFFFFFFF, "R1 output reset");
    chkReg(4'd3, 32'h0, 32'hFFFFFFFF, "R1 enable reset");
    chkReg(4'd7, 32'h2, 32'hFFFFFFFF, "R1 clock control reset");
    chkReg(4'd5, 32'hFFFFFF, 32'hFFFFFFFF, "R1 trigger word0 reset");
    chkReg(4'd6, 32'h7FFF, 32'hFFFFFFFF, "R1 trigger word1 reset");
    chkPort(2, 32'h8000, 32'hFFFF, "R1 output enables reset");
    chkPort(3, 32'h0, 32'h1, "R1 irq reset");
    idle(2);
    countHigh(16, h14, h15);
    report(h15 == 8, "R9 default pin15 clock highs", h15, 8);
    report(h14 == 0, "R1 pin14 idle after reset", h14, 0);

    // R2 direction and data
    wrReg(4'd0, 32'h00FF);
    wrReg(4'd1, 32'h0F0F);
    chkPort(2, 32'h80FF, 32'hFFFF, "R2 output enables");
    chkPort(1, 32'h0F0F, 32'h3FFF, "R2 output data");

    // R3 synchroniser latency
    setIn(16'h1234);
    chkReg(4'd2, 32'h0, 32'hFFFF, "R3 one edge still old");
    chkReg(4'd2, 32'h1234, 32'hFFFF, "R3 two edges new");
    setIn(16'h0000);
    idle(4);

    // R7 level modes: pin0 high level (0), pin1 low level (1), rest off
    wrReg(4'd5, 32'hFFFFC8);
    idle(4);
    chkReg(4'd4, 32'h2, 32'h1FFF, "R7 low level active at 0");
    wrReg(4'd4, 32'h3);
    chkReg(4'd4, 32'h2, 32'h1FFF, "R7 level not cleared by write");
    setIn(16'h0003);
    idle(5);
    chkReg(4'd4, 32'h1, 32'h1FFF, "R7 level follows input");

    // R8 interrupt combine, R4 enable width
    chkPort(3, 32'h0, 32'h1, "R8 irq masked");
    wrReg(4'd3, 32'h1);
    chkPort(3, 32'h1, 32'h1, "R8 irq enabled pin0");
    wrReg(4'd3, 32'h2);
    chkPort(3, 32'h0, 32'h1, "R8 irq other pin enabled");
    wrReg(4'd3, 32'hFFFF);
    chkReg(4'd3, 32'h1FFF, 32'hFFFFFFFF, "R4 enable bits 15:13 read 0");
    wrReg(4'd3, 32'h0);

    // R6/R5 edges: pin2 rise(2), pin3 fall(3), pin4 both(4), others off
    wrReg(4'd5, 32'hFFC6BF);
    idle(2);
    chkReg(4'd4, 32'h0, 32'h1FFF, "R5 off mode clears status");
    setIn(16'h001F);
    idle(5);
    chkReg(4'd4, 32'h14, 32'h1FFF, "R5 rise and both on rising input");
    setIn(16'h0003);
    idle(5);
    chkReg(4'd4, 32'h1C, 32'h1FFF, "R6 sticky after falling input");
    wrReg(4'd4, 32'h04);
    chkReg(4'd4, 32'h18, 32'h1FFF, "R6 write one clears own bit");
    wrReg(4'd4, 32'h0);
    chkReg(4'd4, 32'h18, 32'h1FFF, "R6 write zero no effect");
    wrReg(4'd4, 32'h18);
    chkReg(4'd4, 32'h0, 32'h1FFF, "R6 cleared");

    // R4 pin13 and R5 off pin5 cannot interrupt
    wrReg(4'd3, 32'hFFFF);
    setIn(16'h2023);
    idle(5);
    setIn(16'h0003);
    idle(5);
    chkReg(4'd4, 32'h0, 32'hFFFFFFFF, "R4 pin13 and off pin5 no status");
    chkPort(3, 32'h0, 32'h1, "R4 irq stays low");
    setIn(16'h0007);
    idle(5);
    chkPort(3, 32'h1, 32'h1, "R8 irq from rising pin2");
    wrReg(4'd4, 32'h1FFF);
    wrReg(4'd3, 32'h0);

    // R10 clock modes off: pins 14/15 plain GPIO
    wrReg(4'd0, 32'h40FF);
    wrReg(4'd1, 32'h4F0F);
    wrReg(4'd7, 32'h0);
    chkPort(2, 32'h40FF, 32'hFFFF, "R10 enables follow direction");
    chkPort(1, 32'h4000, 32'hC000, "R10 pins 14/15 follow data");

    // R9 programmed clocks: pin14 H=2 L=0 (period 4), pin15 H=0 L=3 (period 5)
    wrReg(4'd8, 32'h0002);
    wrReg(4'd9, 32'h0300);
    wrReg(4'd7, 32'h3);
    chkReg(4'd9, 32'h0300, 32'hFFFFFFFF, "R9 timing readback");
    chkPort(2, 32'hC0FF, 32'hFFFF, "R9 clock pins driven");
    idle(2);
    countHigh(20, h14, h15);
    report(h14 == 15, "R9 pin14 high count", h14, 15);
    report(h15 == 4, "R9 pin15 high count", h15, 4);

    idle(3);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule